// File: doc/BRIEF.md
# Receive Descriptor Cache with Completion Write-Back

This block sits between a receive-ring descriptor prefetcher and the packet ingress path of a network interface. The prefetcher hands it descriptors read from a host ring, each tagged with its ring index. The block keeps them in a small circular cache, retaining only the packet buffer address and the header buffer address of each one. It also tells the prefetcher how many more descriptors it can take.

When a packet arrives, the block pairs it with the oldest cached descriptor. One cycle later it emits a completion write-back that carries the ring index, the buffer addresses and a status word holding the packet length. If no descriptor is cached, the packet is dropped and a one-cycle drop pulse is raised instead.

Three counters track the cache: the ring index of the oldest entry, the slot that holds it, and the occupancy. All three reset to zero. The ring length is a static configuration input, and every ring index wraps modulo that length. A fetched descriptor whose index is not the next one expected in ring order is rejected and flagged. Only 32-byte descriptors are handled, and header split is not supported.

Top module: `rx_desc_cache`

## Requirements
- R1: After reset, `fetch_room` equals DEPTH, and `wb_valid`, `drop` and `fetch_err` are all 0.
- R2: `fetch_room` always equals DEPTH minus the number of cached descriptors.
- R3: A fetch whose index is the expected one, offered while `fetch_room` is nonzero, is stored and lowers `fetch_room` by one. Descriptors are consumed oldest first, and each write-back returns the addresses that were stored with its index.
- R4: A fetch whose `fetch_idx` differs from (oldest index + count) mod `ring_len` is not stored. `fetch_err` pulses high in the next cycle and `fetch_room` is unchanged.
- R5: A fetch offered while `fetch_room` is 0 is not stored, and `fetch_err` pulses high in the next cycle.
- R6: A packet arriving with an empty cache gives a one-cycle `drop` pulse in the next cycle and no write-back. All counters stay unchanged, which is observed through `fetch_room` and the index of the next write-back.
- R7: A packet arriving with a nonempty cache gives `wb_valid` high for one cycle in the next cycle. The status word has bit 0 (done), bit 1 (end of frame) and bit 3 (L3/L4 checked) set, the packet length in bits 51:38, and all other bits zero.
- R8: Ring indices wrap modulo `ring_len`, both for the index of the next write-back and for the index expected of the next fetch.
- R9: Cache slots are reused circularly, so oldest-first order and the stored addresses are kept across more than DEPTH fetches.
- R10: A fetch accepted in the same cycle as a packet consumes a descriptor leaves `fetch_room` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_len | input | IDX_W | Number of descriptors in the host ring |
| fetch_valid | input | 1 | A fetched descriptor is offered this cycle |
| fetch_idx | input | IDX_W | Ring index of the offered descriptor |
| fetch_pkt_addr | input | 64 | Packet buffer address of the descriptor |
| fetch_hdr_addr | input | 64 | Header buffer address of the descriptor |
| fetch_room | output | CNT_W | Number of further descriptors the cache can accept |
| fetch_err | output | 1 | Pulse: the previous fetch was rejected |
| pkt_valid | input | 1 | A packet has arrived this cycle |
| pkt_len | input | 14 | Length of the arriving packet in bytes |
| wb_valid | output | 1 | Completion write-back is valid |
| wb_idx | output | IDX_W | Ring index being completed |
| wb_pkt_addr | output | 64 | Packet buffer address of the completed descriptor |
| wb_hdr_addr | output | 64 | Header buffer address of the completed descriptor |
| wb_status | output | 64 | Completion status word |
| drop | output | 1 | Pulse: the previous packet was dropped |

## Verification
A wrong occupancy shows at once on `fetch_room`, which is combinational from the count. It also shows one cycle later as a false drop or a false rejection. A wrong oldest index or slot position only shows on the next write-back, as a wrong `wb_idx` or as addresses that belong to another descriptor. For that reason the tests consume every descriptor they fetch and compare each write-back against the values that were fed in. Wrap faults in either modulus only appear after more than DEPTH or `ring_len` operations, so the sequences run past both boundaries.

// File: rtl/rxdc_pkg.sv
package rxdc_pkg;

    localparam int ADDR_W        = 64;
    localparam int LEN_W         = 14;
    localparam int STAT_W        = 64;
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_EOF_BIT  = 1;
    localparam int STAT_CSUM_BIT = 3;
    localparam int STAT_LEN_LSB  = 38;

    typedef struct packed {
        logic [ADDR_W-1:0] pkt_addr;
        logic [ADDR_W-1:0] hdr_addr;
    } rx_buf_pair_t;

    function automatic logic [STAT_W-1:0] completion_word(input logic [LEN_W-1:0] len);
        logic [STAT_W-1:0] w;
        w = '0;
        w[STAT_DONE_BIT] = 1'b1;
        w[STAT_EOF_BIT]  = 1'b1;
        w[STAT_CSUM_BIT] = 1'b1;
        w[STAT_LEN_LSB +: LEN_W] = len;
        return w;
    endfunction

endpackage

// File: rtl/rxdc_tracker.sv
module rxdc_tracker #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 13,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ring_len,
    input  logic              fetch_valid,
    input  logic [IDX_W-1:0]  fetch_idx,
    input  logic              pkt_valid,
    output logic              fetch_accept,
    output logic              fetch_reject,
    output logic              pkt_take,
    output logic              pkt_drop,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] head_slot,
    output logic [IDX_W-1:0]  head_idx,
    output logic [CNT_W-1:0]  occupancy
);

    localparam logic [CNT_W-1:0]  FULL_CNT   = CNT_W'(DEPTH);
    localparam logic [SLOT_W:0]   DEPTH_WIDE = (SLOT_W+1)'(DEPTH);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(DEPTH - 1);

    logic [IDX_W-1:0]  first_q;
    logic [SLOT_W-1:0] pos_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [IDX_W:0]    idx_sum;
    logic [IDX_W-1:0]  expect_idx;
    logic [SLOT_W:0]   slot_sum;
    logic [IDX_W:0]    first_inc;
    logic [IDX_W-1:0]  first_nxt;
    logic [SLOT_W-1:0] pos_nxt;

    always_comb begin
        idx_sum = {1'b0, first_q} + (IDX_W+1)'(cnt_q);
        if (idx_sum >= {1'b0, ring_len})
            idx_sum = idx_sum - {1'b0, ring_len};
        expect_idx = idx_sum[IDX_W-1:0];

        slot_sum = {1'b0, pos_q} + (SLOT_W+1)'(cnt_q);
        if (slot_sum >= DEPTH_WIDE)
            slot_sum = slot_sum - DEPTH_WIDE;
        wr_slot = slot_sum[SLOT_W-1:0];

        first_inc = {1'b0, first_q} + (IDX_W+1)'(1);
        first_nxt = (first_inc >= {1'b0, ring_len}) ? '0 : first_inc[IDX_W-1:0];
        pos_nxt   = (pos_q == LAST_SLOT) ? '0 : pos_q + SLOT_W'(1);
    end

    assign fetch_accept = fetch_valid && (cnt_q != FULL_CNT) && (fetch_idx == expect_idx);
    assign fetch_reject = fetch_valid && !fetch_accept;
    assign pkt_take     = pkt_valid && (cnt_q != '0);
    assign pkt_drop     = pkt_valid && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            pos_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (pkt_take) begin
                first_q <= first_nxt;
                pos_q   <= pos_nxt;
            end
            case ({fetch_accept, pkt_take})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_slot = pos_q;
    assign head_idx  = first_q;
    assign occupancy = cnt_q;

endmodule

// File: rtl/rxdc_slot_store.sv
module rxdc_slot_store
    import rxdc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  rx_buf_pair_t      wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output rx_buf_pair_t      rd_data
);

    rx_buf_pair_t slots [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == SLOT_W'(s)))
                slots[s] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (rd_slot == SLOT_W'(s))
                rd_data = slots[s];
        end
    end

endmodule

// File: rtl/rxdc_wb_reg.sv
module rxdc_wb_reg
    import rxdc_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              drop_in,
    input  logic              reject_in,
    input  logic [IDX_W-1:0]  idx_in,
    input  rx_buf_pair_t      bufs_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output rx_buf_pair_t      wb_bufs,
    output logic [STAT_W-1:0] wb_status,
    output logic              drop,
    output logic              fetch_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid  <= 1'b0;
            drop      <= 1'b0;
            fetch_err <= 1'b0;
            wb_idx    <= '0;
            wb_bufs   <= '0;
            wb_status <= '0;
        end else begin
            wb_valid  <= take;
            drop      <= drop_in;
            fetch_err <= reject_in;
            if (take) begin
                wb_idx    <= idx_in;
                wb_bufs   <= bufs_in;
                wb_status <= completion_word(len_in);
            end
        end
    end

endmodule

// File: rtl/rx_desc_cache.sv
module rx_desc_cache
    import rxdc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 13,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ring_len,
    input  logic              fetch_valid,
    input  logic [IDX_W-1:0]  fetch_idx,
    input  logic [63:0]       fetch_pkt_addr,
    input  logic [63:0]       fetch_hdr_addr,
    output logic [CNT_W-1:0]  fetch_room,
    output logic              fetch_err,
    input  logic              pkt_valid,
    input  logic [13:0]       pkt_len,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [63:0]       wb_pkt_addr,
    output logic [63:0]       wb_hdr_addr,
    output logic [63:0]       wb_status,
    output logic              drop
);

    logic              f_acc, f_rej, p_take, p_drop;
    logic [SLOT_W-1:0] w_slot, h_slot;
    logic [IDX_W-1:0]  h_idx;
    logic [CNT_W-1:0]  occ;
    rx_buf_pair_t      in_pair, head_pair, out_pair;

    assign in_pair.pkt_addr = fetch_pkt_addr;
    assign in_pair.hdr_addr = fetch_hdr_addr;

    rxdc_tracker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .ring_len     (ring_len),
        .fetch_valid  (fetch_valid),
        .fetch_idx    (fetch_idx),
        .pkt_valid    (pkt_valid),
        .fetch_accept (f_acc),
        .fetch_reject (f_rej),
        .pkt_take     (p_take),
        .pkt_drop     (p_drop),
        .wr_slot      (w_slot),
        .head_slot    (h_slot),
        .head_idx     (h_idx),
        .occupancy    (occ)
    );

    rxdc_slot_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (f_acc),
        .wr_slot (w_slot),
        .wr_data (in_pair),
        .rd_slot (h_slot),
        .rd_data (head_pair)
    );

    rxdc_wb_reg #(.IDX_W(IDX_W)) u_wb (
        .clk       (clk),
        .rst       (rst),
        .take      (p_take),
        .drop_in   (p_drop),
        .reject_in (f_rej),
        .idx_in    (h_idx),
        .bufs_in   (head_pair),
        .len_in    (pkt_len),
        .wb_valid  (wb_valid),
        .wb_idx    (wb_idx),
        .wb_bufs   (out_pair),
        .wb_status (wb_status),
        .drop      (drop),
        .fetch_err (fetch_err)
    );

    assign fetch_room  = CNT_W'(DEPTH) - occ;
    assign wb_pkt_addr = out_pair.pkt_addr;
    assign wb_hdr_addr = out_pair.hdr_addr;

endmodule

// File: rtl/rx_desc_cache_chk.sv
module rx_desc_cache_chk #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 13,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fetch_valid,
    input logic [CNT_W-1:0] fetch_room,
    input logic             fetch_err,
    input logic             pkt_valid,
    input logic             wb_valid,
    input logic [63:0]      wb_status,
    input logic             drop
);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    a_r2_room_bound: assert property (@(posedge clk) disable iff (rst)
        fetch_room <= CNT_W'(DEPTH));

    a_r6_drop_no_wb: assert property (@(posedge clk) disable iff (rst)
        drop |-> !wb_valid);

    a_r6_drop_when_empty: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(pkt_valid) && $past(fetch_room) == CNT_W'(DEPTH)) |-> drop);

    a_r7_wb_after_pkt: assert property (@(posedge clk) disable iff (rst)
        (seen && wb_valid) |-> $past(pkt_valid));

    a_r7_status_flags: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_status[0] && wb_status[1] && wb_status[3] && !wb_status[2]));

    a_r5_full_rejects: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(fetch_valid) && $past(fetch_room) == '0) |-> fetch_err);

    a_r10_room_steady: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(fetch_valid) && $past(pkt_valid) && !fetch_err
         && $past(fetch_room) != CNT_W'(DEPTH)) |-> fetch_room == $past(fetch_room));

    a_r3_room_drops: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(fetch_valid) && !$past(pkt_valid) && !fetch_err)
        |-> fetch_room == $past(fetch_room) - CNT_W'(1));

endmodule

bind rx_desc_cache rx_desc_cache_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_room  (fetch_room),
    .fetch_err   (fetch_err),
    .pkt_valid   (pkt_valid),
    .wb_valid    (wb_valid),
    .wb_status   (wb_status),
    .drop        (drop)
);

// File: tb/rx_desc_cache_tb.sv
module rx_desc_cache_tb;

    localparam int DEPTH = 4;
    localparam int IDX_W = 13;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int RLEN  = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IDX_W-1:0] ring_len = IDX_W'(RLEN);
    logic             fetch_valid = 1'b0;
    logic [IDX_W-1:0] fetch_idx = '0;
    logic [63:0]      fetch_pkt_addr = '0;
    logic [63:0]      fetch_hdr_addr = '0;
    logic [CNT_W-1:0] fetch_room;
    logic             fetch_err;
    logic             pkt_valid = 1'b0;
    logic [13:0]      pkt_len = '0;
    logic             wb_valid;
    logic [IDX_W-1:0] wb_idx;
    logic [63:0]      wb_pkt_addr, wb_hdr_addr, wb_status;
    logic             drop;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    rx_desc_cache #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .ring_len(ring_len),
        .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
        .fetch_pkt_addr(fetch_pkt_addr), .fetch_hdr_addr(fetch_hdr_addr),
        .fetch_room(fetch_room), .fetch_err(fetch_err),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_pkt_addr(wb_pkt_addr), .wb_hdr_addr(wb_hdr_addr),
        .wb_status(wb_status), .drop(drop)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pa(input int i); return 64'h1000_0000 + 64'(i) * 64'h100; endfunction
    function automatic logic [63:0] ha(input int i); return 64'h2000_0000 + 64'(i) * 64'h40; endfunction
    function automatic logic [63:0] exp_status(input int len);
        return 64'h1 | 64'h2 | 64'h8 | (64'(len) << 38);
    endfunction

    // fetch one descriptor; addr tag a picks its addresses
    task automatic fetch_one(input int idx, input int a, input bit exp_err, input int exp_room);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_idx = IDX_W'(idx);
        fetch_pkt_addr = pa(a); fetch_hdr_addr = ha(a);
        @(negedge clk);
        fetch_valid = 1'b0;
        check(exp_err ? "R4/R5 reject flag" : "R3 accept flag", 64'(fetch_err), 64'(exp_err));
        check("R2 room after fetch", 64'(fetch_room), 64'(exp_room));
    endtask

    task automatic consume_one(input int len, input int exp_idx, input int a, input int exp_room);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = 14'(len);
        @(negedge clk);
        pkt_valid = 1'b0;
        check("R7 wb_valid", 64'(wb_valid), 64'd1);
        check("R7 drop low", 64'(drop), 64'd0);
        check("R3/R8 wb_idx", 64'(wb_idx), 64'(exp_idx));
        check("R3/R9 pkt addr", wb_pkt_addr, pa(a));
        check("R3/R9 hdr addr", wb_hdr_addr, ha(a));
        check("R7 status", wb_status, exp_status(len));
        check("R2 room after consume", 64'(fetch_room), 64'(exp_room));
        @(negedge clk);
        check("R7 wb one cycle", 64'(wb_valid), 64'd0);
    endtask

    task automatic t_reset();
        check("R1 room", 64'(fetch_room), 64'(DEPTH));
        check("R1 wb_valid", 64'(wb_valid), 64'd0);
        check("R1 drop", 64'(drop), 64'd0);
        check("R1 fetch_err", 64'(fetch_err), 64'd0);
    endtask

    task automatic t_drop_empty();
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = 14'd60;
        @(negedge clk);
        pkt_valid = 1'b0;
        check("R6 drop pulse", 64'(drop), 64'd1);
        check("R6 no wb", 64'(wb_valid), 64'd0);
        check("R6 room kept", 64'(fetch_room), 64'(DEPTH));
        @(negedge clk);
        check("R6 drop one cycle", 64'(drop), 64'd0);
    endtask

    task automatic t_fill_and_overflow();
        for (int i = 0; i < DEPTH; i++) fetch_one(i, i, 1'b0, DEPTH - 1 - i);
        fetch_one(4, 9, 1'b1, 0);  // R5 full
    endtask

    task automatic t_order_and_wrap();
        consume_one(64, 0, 0, 1);
        consume_one(1500, 1, 1, 2);
        fetch_one(5, 7, 1'b1, 2);  // R4 expected 4
        fetch_one(4, 4, 1'b0, 1);
        fetch_one(5, 5, 1'b0, 0);
        consume_one(100, 2, 2, 1);
        consume_one(200, 3, 3, 2);
        consume_one(16383, 4, 4, 3);  // R9 slot reused
        consume_one(1, 5, 5, 4);
        // ring now at index 0 again (R8); check drop keeps head index (R6)
        t_drop_empty();
        fetch_one(0, 10, 1'b0, 3);
    endtask

    task automatic t_simultaneous();
        @(negedge clk);
        fetch_valid = 1'b1; fetch_idx = IDX_W'(1);
        fetch_pkt_addr = pa(11); fetch_hdr_addr = ha(11);
        pkt_valid = 1'b1; pkt_len = 14'd77;
        @(negedge clk);
        fetch_valid = 1'b0; pkt_valid = 1'b0;
        check("R10 room unchanged", 64'(fetch_room), 64'(DEPTH - 1));
        check("R10 no reject", 64'(fetch_err), 64'd0);
        check("R10 wb idx", 64'(wb_idx), 64'd0);
        check("R10 wb addr", wb_pkt_addr, pa(10));
        consume_one(90, 1, 11, DEPTH);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_drop_empty();
        t_fill_and_overflow();
        t_order_and_wrap();
        t_simultaneous();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule